// File: doc/BRIEF.md
# Repeating Calendar Alarm

This block stores an alarm time as four BCD bytes: second, minute, hour and day of month. An external calendar counter supplies the current BCD time and a one-cycle strobe once per second. On each strobe the block compares the current time with the stored alarm. When they match, it raises a single-cycle interrupt pulse.

Bit 7 of each alarm byte is a mask flag. Together the four flags choose how often the alarm repeats: once a month, once a day, once an hour, once a minute, or on every second. In each mode only the fields that the mode names take part in the comparison.

Software programs the alarm through a byte-wide port. A write whose BCD field is out of range is dropped, so the stored alarm always holds a valid time. Register addresses are 0 for second, 1 for minute, 2 for hour and 3 for day.

Top module: `cal_alarm`

## Requirements
- R1: A synchronous active-high reset clears all four alarm bytes, the read data output and the interrupt output to zero.
- R2: An accepted write stores the full byte, including bit 7, at the addressed register. The read data output shows the byte at `reg_addr` one clock edge after the address is presented.
- R3: A write to the second register (address 0) or the minute register (address 1) is accepted only if bits 6:0 form valid BCD in the range 00 to 59. Valid BCD means the units digit is at most 9. Any other write leaves the register unchanged.
- R4: A write to the hour register (address 2) is accepted only if bits 5:0 form valid BCD in the range 00 to 23. Otherwise the register is unchanged.
- R5: A write to the day register (address 3) is accepted only if bits 5:0 form valid BCD in the range 01 to 31. Otherwise the register is unchanged.
- R6: With all four mask bits clear, a strobe fires the alarm only when day, hour, minute and second all match.
- R7: With only the day mask set, a strobe fires the alarm when hour, minute and second match, whatever the day.
- R8: With the day and hour masks set and the minute and second masks clear, a strobe fires the alarm when minute and second match.
- R9: With the day, hour and minute masks set and the second mask clear, a strobe fires the alarm when the second matches.
- R10: Any mask combination not listed in R6 to R9 fires the alarm on every strobe.
- R11: The interrupt is high for exactly one cycle, in the cycle after a strobe that matched. It never rises without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the alarm registers |
| reg_addr | input | 2 | Register select: 0 second, 1 minute, 2 hour, 3 day |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 7 | Current second, BCD |
| now_min | input | 7 | Current minute, BCD |
| now_hour | input | 6 | Current hour, BCD |
| now_day | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
A corrupted alarm byte shows up on `reg_rdata` one edge after its address is selected. A wrong mask or a wrong field compare shows up as a missing or extra pulse on `alarm_irq`, one edge after the next strobe. Each repeat mode is therefore driven with one strobe where only a don't-care field differs and one where a compared field differs. Dropped writes are checked by reading back the register afterwards, and the pulse width is checked in the cycle after each pulse.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int NUM_FIELDS = 4;
  localparam int FLD_SEC    = 0;
  localparam int FLD_MIN    = 1;
  localparam int FLD_HOUR   = 2;
  localparam int FLD_DAY    = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_mode_e;

  function automatic int field_width(input int idx);
    return (idx == FLD_SEC || idx == FLD_MIN) ? 7 : 6;
  endfunction

  function automatic int field_lo(input int idx);
    return (idx == FLD_DAY) ? 1 : 0;
  endfunction

  function automatic int field_hi(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 59;
      FLD_HOUR:         return 23;
      default:          return 31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_field_chk.sv
module bcd_field_chk #(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 7,
  parameter int LO      = 0,
  parameter int HI      = 59
) (
  input  logic [DATA_W-1:0] value,
  output logic              in_range
);
  localparam int TENS_W = FIELD_W - 4;

  logic [TENS_W-1:0] tens;
  logic [3:0]        units;
  int                dec;

  always_comb begin
    tens     = value[FIELD_W-1:4];
    units    = value[3:0];
    dec      = int'(tens) * 10 + int'(units);
    in_range = (units <= 4'd9) && (dec >= LO) && (dec <= HI);
  end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q
);
  logic [NUM_FIELDS-1:0] wr_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_chk
    bcd_field_chk #(
      .DATA_W (DATA_W),
      .FIELD_W(field_width(i)),
      .LO     (field_lo(i)),
      .HI     (field_hi(i))
    ) chk_i (
      .value   (wdata),
      .in_range(wr_ok[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
      rdata   <= '0;
    end else begin
      if (we && wr_ok[addr]) alarm_q[addr] <= wdata;
      rdata <= alarm_q[addr];
    end
  end

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_ok[addr]) |=> $stable(alarm_q)); // R3
  AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (alarm_q[FLD_SEC][6:4] <= 3'd5) && (alarm_q[FLD_SEC][3:0] <= 4'd9)); // R3
  AST_HOUR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (alarm_q[FLD_HOUR][3:0] <= 4'd9) && (alarm_q[FLD_HOUR][5:0] <= 6'h23)); // R4
  AST_DAY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (alarm_q[FLD_DAY][3:0] <= 4'd9) && (alarm_q[FLD_DAY][5:0] <= 6'h31)); // R5
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEC_W  = 7,
  parameter int HOUR_W = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q,
  input  logic                              tick,
  input  logic [SEC_W-1:0]                  t_sec,
  input  logic [SEC_W-1:0]                  t_min,
  input  logic [HOUR_W-1:0]                 t_hour,
  input  logic [HOUR_W-1:0]                 t_day,
  output logic                              irq
);
  localparam int MASK_BIT = DATA_W - 1;

  logic [NUM_FIELDS-1:0] masks;
  rpt_mode_e             mode;
  logic eq_s, eq_m, eq_h, eq_d, hit;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_mask
    assign masks[i] = alarm_q[i][MASK_BIT];
  end

  always_comb begin
    // masks index order: {day, hour, minute, second}
    case (masks)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MIN;
      default: mode = RPT_SEC;
    endcase
    eq_s = alarm_q[FLD_SEC][SEC_W-1:0]   == t_sec;
    eq_m = alarm_q[FLD_MIN][SEC_W-1:0]   == t_min;
    eq_h = alarm_q[FLD_HOUR][HOUR_W-1:0] == t_hour;
    eq_d = alarm_q[FLD_DAY][HOUR_W-1:0]  == t_day;
    case (mode)
      RPT_MONTH: hit = eq_d && eq_h && eq_m && eq_s;
      RPT_DAY:   hit = eq_h && eq_m && eq_s;
      RPT_HOUR:  hit = eq_m && eq_s;
      RPT_MIN:   hit = eq_s;
      default:   hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= tick && hit;
  end

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tick)); // R11
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (irq && !tick) |=> !irq); // R11
  AST_EVERY_SEC_FIRES: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == RPT_SEC) |=> irq); // R10
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int SEC_W  = 7,
  parameter int HOUR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sec_tick,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [SEC_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [HOUR_W-1:0] now_day,
  output logic              alarm_irq
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_q;

  alarm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .alarm_q(alarm_q)
  );

  alarm_match #(.DATA_W(DATA_W), .SEC_W(SEC_W), .HOUR_W(HOUR_W)) match_i (
    .clk    (clk),
    .rst    (rst),
    .alarm_q(alarm_q),
    .tick   (sec_tick),
    .t_sec  (now_sec),
    .t_min  (now_min),
    .t_hour (now_hour),
    .t_day  (now_day),
    .irq    (alarm_irq)
  );
endmodule

// File: tb/cal_alarm_tb_top.sv
module cal_alarm_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sec_tick = 1'b0;
  logic [6:0] now_sec = '0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [5:0] now_day = '0;
  logic       alarm_irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cal_alarm dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .alarm_irq(alarm_irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata, exp, tag);
  endtask

  task automatic tick_chk(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d,
                          input logic exp, input string tag);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_day = d; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    chk(alarm_irq, exp, tag);
    @(negedge clk);
    chk(alarm_irq, 0, {tag, " pulse end R11"});
  endtask

  task automatic set_alarm(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
    wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
  endtask

  task automatic test_reset;
    for (int i = 0; i < 4; i++) rd_chk(i[1:0], 8'h00, "R1 reset value");
    chk(alarm_irq, 0, "R1 irq after reset");
  endtask

  task automatic test_rw;
    set_alarm(8'hD9, 8'h00, 8'hA3, 8'h31);
    rd_chk(2'd0, 8'hD9, "R2 sec readback");
    rd_chk(2'd1, 8'h00, "R2 min readback");
    rd_chk(2'd2, 8'hA3, "R2 hour readback");
    rd_chk(2'd3, 8'h31, "R2 day readback");
  endtask

  task automatic test_reject;
    wr(2'd0, 8'h60); rd_chk(2'd0, 8'hD9, "R3 sec 60 rejected");
    wr(2'd0, 8'h4A); rd_chk(2'd0, 8'hD9, "R3 sec bad digit rejected");
    wr(2'd1, 8'h7F); rd_chk(2'd1, 8'h00, "R3 min 7F rejected");
    wr(2'd1, 8'h59); rd_chk(2'd1, 8'h59, "R3 min 59 accepted");
    wr(2'd2, 8'h24); rd_chk(2'd2, 8'hA3, "R4 hour 24 rejected");
    wr(2'd2, 8'h1C); rd_chk(2'd2, 8'hA3, "R4 hour bad digit rejected");
    wr(2'd3, 8'h00); rd_chk(2'd3, 8'h31, "R5 day 00 rejected");
    wr(2'd3, 8'h32); rd_chk(2'd3, 8'h31, "R5 day 32 rejected");
    wr(2'd3, 8'h01); rd_chk(2'd3, 8'h01, "R5 day 01 accepted");
  endtask

  task automatic test_modes;
    set_alarm(8'h30, 8'h15, 8'h12, 8'h07);
    tick_chk(7'h30, 7'h15, 6'h12, 6'h07, 1'b1, "R6 month match");
    tick_chk(7'h30, 7'h15, 6'h12, 6'h08, 1'b0, "R6 month day differs");
    wr(2'd3, 8'h87);
    tick_chk(7'h30, 7'h15, 6'h12, 6'h08, 1'b1, "R7 day mode ignores day");
    tick_chk(7'h30, 7'h15, 6'h13, 6'h07, 1'b0, "R7 day mode hour differs");
    wr(2'd2, 8'h92);
    tick_chk(7'h30, 7'h15, 6'h05, 6'h20, 1'b1, "R8 hour mode ignores hour");
    tick_chk(7'h30, 7'h16, 6'h12, 6'h07, 1'b0, "R8 hour mode min differs");
    wr(2'd1, 8'h95);
    tick_chk(7'h30, 7'h40, 6'h05, 6'h20, 1'b1, "R9 minute mode ignores min");
    tick_chk(7'h31, 7'h15, 6'h12, 6'h07, 1'b0, "R9 minute mode sec differs");
    wr(2'd0, 8'hB0);
    tick_chk(7'h01, 7'h02, 6'h03, 6'h04, 1'b1, "R10 all masks every tick");
    set_alarm(8'hB0, 8'h15, 8'h12, 8'h07);
    tick_chk(7'h01, 7'h02, 6'h03, 6'h04, 1'b1, "R10 sec mask only every tick");
    set_alarm(8'h30, 8'h15, 8'h92, 8'h07);
    tick_chk(7'h59, 7'h59, 6'h23, 6'h31, 1'b1, "R10 hour mask only every tick");
  endtask

  task automatic test_no_tick;
    set_alarm(8'h30, 8'h15, 8'h12, 8'h07);
    @(negedge clk);
    now_sec = 7'h30; now_min = 7'h15; now_hour = 6'h12; now_day = 6'h07;
    repeat (3) begin
      @(negedge clk);
      chk(alarm_irq, 0, "R11 no irq without tick");
    end
  endtask

  task automatic test_reset_again;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_chk(2'd2, 8'h00, "R1 reset clears hour");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset;
    test_rw;
    test_reject;
    test_modes;
    test_no_tick;
    test_reset_again;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule